// File: doc/BRIEF.md
# Microsecond Timer with Alarms

This block keeps a 64-bit count of microseconds since reset and provides four one-shot alarms. An external one-cycle tick pulse, produced elsewhere once per microsecond, advances the count. Software reaches the count and the alarms through a small word-addressed register bus whose reads return data in the same cycle.

The count is reached as two 32-bit halves, and the access order makes it coherent. When software sets the time, the low half is staged and the whole 64-bit value is loaded when the high half is written. When software reads the time, reading the low half captures the matching high half, so a later high-half read agrees with it even if the count has carried in between.

Each alarm compares a 32-bit target with the low half of the count. Writing a target arms the alarm if that alarm is enabled, and the alarm's running flag is then set. When the count matches on a tick, the alarm fires: its sticky interrupt bit is set and its running flag drops. Clearing the enable cancels a pending alarm. Each interrupt output is that alarm's sticky bit gated by an interrupt enable.

Top module: `usTimer`

## Requirements
- R1: After reset the count, the enables, the running flags, the sticky interrupt bits and the interrupt enables are all zero, and every irq output is low.
- R2: In each cycle with tick high the count rises by one, carrying from the low half into the high half. With tick low and no high-half write, the count holds.
- R3: A write to address 0 stages the low half and leaves the count unchanged. A write to address 1 loads the count with {written data, staged low half} at that clock edge, and this load takes priority over a tick in the same cycle.
- R4: A read of address 0 returns count[31:0] and captures count[63:32]. A read of address 1 returns that captured value, which does not change until the next read of address 0.
- R5: A write to the target register of alarm i (address 2+i) stores the target. If bit i of the enable register (address 6) is set, the write also sets alarm i's running flag. The running flags read at address 7, with bit i belonging to alarm i.
- R6: A target write to an alarm whose enable bit is clear does not set its running flag.
- R7: An alarm fires in a tick cycle where it is running and the current count[31:0] equals its target. After that edge its sticky bit (address 8, bit i) is 1 and its running flag is 0.
- R8: Writing 0 to an alarm's enable bit clears its running flag at that edge. The alarm then does not fire, even if the count later passes its target.
- R9: Writing 1 to bit i of address 8 clears sticky bit i, and bits written as 0 leave their sticky bits unchanged. If a fire and a clear of the same bit happen in the same cycle, the bit ends up set.
- R10: irq[i] is high exactly when sticky bit i and interrupt enable bit i (address 9) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-microsecond advance pulse |
| busValid | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 4 | Per-alarm level interrupts |

## Verification
The assertions check on every cycle that the count increments on a tick and holds without one, that a high-half write loads the staged value, that a running flag is never high while its enable is clear, that a match sets the sticky bit and drops the running flag, and that a sticky bit stays set until a 1 is written to it. Only the bench's scenarios can show that the halves stay coherent when a carry happens between the two reads, that a target written while the enable is clear leaves the alarm idle, and that firing follows the exact tick count implied by a target set ahead of a randomly chosen count.

// File: rtl/usTimerPkg.sv
package usTimerPkg;
  localparam int NUM_ALARMS = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W = 2 * DATA_W;
  localparam int ADDR_W = 4;

  localparam int ADDR_TIME_LO  = 0;
  localparam int ADDR_TIME_HI  = 1;
  localparam int ADDR_TGT_BASE = 2;
  localparam int ADDR_ALM_EN   = ADDR_TGT_BASE + NUM_ALARMS;
  localparam int ADDR_RUNNING  = ADDR_ALM_EN + 1;
  localparam int ADDR_INT_RAW  = ADDR_RUNNING + 1;
  localparam int ADDR_INT_EN   = ADDR_INT_RAW + 1;

  typedef struct packed {
    logic                  wrLo;
    logic                  wrHi;
    logic                  rdLo;
    logic [NUM_ALARMS-1:0] wrTarget;
    logic                  wrAlmEn;
    logic                  wrIntClr;
    logic                  wrIntEn;
  } strobe_t;
endpackage

// File: rtl/usTimerCtrl.sv
module usTimerCtrl
  import usTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  logic isWr;
  logic isRd;

  assign isWr = busValid && busWrite;
  assign isRd = busValid && !busWrite;

  always_comb begin
    strobe = '0;
    strobe.wrLo     = isWr && (busAddr == ADDR_W'(ADDR_TIME_LO));
    strobe.wrHi     = isWr && (busAddr == ADDR_W'(ADDR_TIME_HI));
    strobe.rdLo     = isRd && (busAddr == ADDR_W'(ADDR_TIME_LO));
    strobe.wrAlmEn  = isWr && (busAddr == ADDR_W'(ADDR_ALM_EN));
    strobe.wrIntClr = isWr && (busAddr == ADDR_W'(ADDR_INT_RAW));
    strobe.wrIntEn  = isWr && (busAddr == ADDR_W'(ADDR_INT_EN));
    for (int i = 0; i < NUM_ALARMS; i++) begin
      strobe.wrTarget[i] = isWr && (busAddr == ADDR_W'(ADDR_TGT_BASE + i));
    end
  end

  // R3, R5: a single bus access raises at most one strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe) <= 1);
  a_r4_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (strobe == '0));
endmodule

// File: rtl/usTimerData.sv
module usTimerData
  import usTimerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  strobe_t               strobe,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_ALARMS-1:0] irq
);
  logic [CNT_W-1:0]      count;
  logic [DATA_W-1:0]     stageLo;
  logic [DATA_W-1:0]     latchHi;
  logic [DATA_W-1:0]     target [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] almEn;
  logic [NUM_ALARMS-1:0] running;
  logic [NUM_ALARMS-1:0] intRaw;
  logic [NUM_ALARMS-1:0] intEn;
  logic [NUM_ALARMS-1:0] match;
  logic [NUM_ALARMS-1:0] cancel;
  logic [NUM_ALARMS-1:0] fire;

  // counter and coherent-access registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      stageLo <= '0;
      latchHi <= '0;
    end else begin
      if (strobe.wrHi)      count <= {wdata, stageLo};
      else if (tick)        count <= count + 1'b1;
      if (strobe.wrLo)      stageLo <= wdata;
      if (strobe.rdLo)      latchHi <= count[CNT_W-1:DATA_W];
    end
  end

  // alarm comparators
  always_comb begin
    for (int i = 0; i < NUM_ALARMS; i++) begin
      match[i]  = tick && running[i] && (count[DATA_W-1:0] == target[i]);
      cancel[i] = strobe.wrAlmEn && !wdata[i];
      fire[i]   = match[i] && !cancel[i] && !strobe.wrTarget[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almEn   <= '0;
      intEn   <= '0;
      running <= '0;
      intRaw  <= '0;
      for (int i = 0; i < NUM_ALARMS; i++) target[i] <= '0;
    end else begin
      if (strobe.wrAlmEn) almEn <= wdata[NUM_ALARMS-1:0];
      if (strobe.wrIntEn) intEn <= wdata[NUM_ALARMS-1:0];
      for (int i = 0; i < NUM_ALARMS; i++) begin
        if (strobe.wrTarget[i]) target[i] <= wdata;
        if (cancel[i])               running[i] <= 1'b0;
        else if (strobe.wrTarget[i]) running[i] <= almEn[i];
        else if (fire[i])            running[i] <= 1'b0;
        if (fire[i])                              intRaw[i] <= 1'b1;
        else if (strobe.wrIntClr && wdata[i])     intRaw[i] <= 1'b0;
      end
    end
  end

  assign irq = intRaw & intEn;

  // read mux
  always_comb begin
    rdata = '0;
    if (busAddr == ADDR_W'(ADDR_TIME_LO))      rdata = count[DATA_W-1:0];
    else if (busAddr == ADDR_W'(ADDR_TIME_HI)) rdata = latchHi;
    else if (busAddr == ADDR_W'(ADDR_ALM_EN))  rdata[NUM_ALARMS-1:0] = almEn;
    else if (busAddr == ADDR_W'(ADDR_RUNNING)) rdata[NUM_ALARMS-1:0] = running;
    else if (busAddr == ADDR_W'(ADDR_INT_RAW)) rdata[NUM_ALARMS-1:0] = intRaw;
    else if (busAddr == ADDR_W'(ADDR_INT_EN))  rdata[NUM_ALARMS-1:0] = intEn;
    else begin
      for (int i = 0; i < NUM_ALARMS; i++) begin
        if (busAddr == ADDR_W'(ADDR_TGT_BASE + i)) rdata = target[i];
      end
    end
  end

  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.wrHi) |=> (count == $past(count) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.wrHi) |=> $stable(count));
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHi |=> (count[CNT_W-1:DATA_W] == $past(wdata)));
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLo |=> $stable(latchHi));

  generate
    for (genvar g = 0; g < NUM_ALARMS; g++) begin : gAlarmChk
      a_r8_no_run_disabled: assert property (@(posedge clk) disable iff (!rstN)
        !almEn[g] |-> !running[g]);
      a_r7_fire: assert property (@(posedge clk) disable iff (!rstN)
        (running[g] && tick && (count[DATA_W-1:0] == target[g]) &&
         !strobe.wrAlmEn && !strobe.wrTarget[g]) |=> (intRaw[g] && !running[g]));
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (intRaw[g] && !(strobe.wrIntClr && wdata[g])) |=> intRaw[g]);
    end
  endgenerate
endmodule

// File: rtl/usTimer.sv
module usTimer
  import usTimerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_ALARMS-1:0] irq
);
  strobe_t strobe;

  usTimerCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  usTimerData uData (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .strobe  (strobe),
    .wdata   (busWdata),
    .busAddr (busAddr),
    .rdata   (busRdata),
    .irq     (irq)
  );
endmodule

// File: tb/usTimer_test.sv
`timescale 1ns/1ps
module usTimer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irq;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;
  logic [63:0] mCnt = '0;
  logic [31:0] mStage = '0;
  logic [31:0] lastRd;

  always #2.5 clk = ~clk;

  usTimer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  function automatic logic [63:0] joinHalves(input logic [31:0] hi, input logic [31:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [3:0] bitOf(input int a);
    return 4'(1 << a);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle with the given inputs; model of the counter updated at the edge
  task automatic cyc(input logic t, input logic v, input logic w,
                     input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; busValid = v; busWrite = w; busAddr = a; busWdata = d;
    #1 lastRd = busRdata;
    @(posedge clk);
    if (v && w && a == 4'd1) mCnt = joinHalves(d, mStage);
    else if (t) mCnt = mCnt + 64'd1;
    if (v && w && a == 4'd0) mStage = d;
    #0.5;
    tick = 1'b0; busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(1'b0, 1'b1, 1'b0, a, 32'd0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic readCount(output logic [63:0] v);
    logic [31:0] lo;
    rd(4'd0); lo = lastRd;
    rd(4'd1); v = joinHalves(lastRd, lo);
  endtask

  task automatic setCount(input logic [63:0] v);
    wr(4'd0, v[31:0]);
    wr(4'd1, v[63:32]);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    logic [31:0] loSnap;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readCount(got);            chk("R1 count", got, 64'd0);
    rd(4'd6);                  chk("R1 enable", lastRd, 0);
    rd(4'd7);                  chk("R1 running", lastRd, 0);
    rd(4'd8);                  chk("R1 sticky", lastRd, 0);
    rd(4'd9);                  chk("R1 irq enable", lastRd, 0);
    chk("R1 irq", irq, 0);

    // R2 directed tick/hold
    ticks(5);
    cyc(1'b0, 1'b0, 1'b0, 4'd0, 32'd0);
    cyc(1'b0, 1'b0, 1'b0, 4'd0, 32'd0);
    readCount(got);            chk("R2 five ticks", got, 64'd5);

    // R3 low write stages only; high write loads and beats a tick
    wr(4'd0, 32'hDEAD_0000);
    rd(4'd0);                  chk("R3 low stage no effect", lastRd, 32'd5);
    cyc(1'b1, 1'b1, 1'b1, 4'd1, 32'h0000_1234);
    readCount(got);            chk("R3 high load over tick", got, 64'h0000_1234_DEAD_0000);

    // R4 coherent halves across a carry
    setCount(64'h0000_0005_FFFF_FFFE);
    rd(4'd0);                  chk("R4 low read", lastRd, 32'hFFFF_FFFE);
    ticks(4);
    rd(4'd1);                  chk("R4 latched high", lastRd, 32'd5);
    readCount(got);            chk("R2 carry", got, 64'h0000_0006_0000_0002);

    // R2/R4 random counter runs
    for (int it = 0; it < 30; it++) begin
      logic [63:0] seed;
      int n;
      seed = joinHalves($urandom, 32'hFFFF_FFC0 | 32'($urandom % 64));
      setCount(seed);
      n = $urandom % 80;
      for (int k = 0; k < n; k++) cyc(1'($urandom % 2), 1'b0, 1'b0, 4'd0, 32'd0);
      readCount(got);          chk("R2 random run", got, mCnt);
    end

    // R5/R6/R7/R8/R10 directed alarms
    setCount(64'd100);
    wr(4'd6, 32'b0101);
    wr(4'd2, 32'd103);
    wr(4'd3, 32'd101);
    wr(4'd4, 32'd110);
    wr(4'd5, 32'd0);
    rd(4'd7);                  chk("R5 R6 running after arm", lastRd, 32'b0101);
    ticks(3);
    rd(4'd8);                  chk("R7 no early fire", lastRd, 0);
    ticks(1);
    rd(4'd8);                  chk("R7 sticky set", lastRd, 32'b0001);
    rd(4'd7);                  chk("R7 running cleared", lastRd, 32'b0100);
    chk("R10 irq masked", irq, 4'b0000);
    wr(4'd9, 32'hF);
    @(negedge clk);            chk("R10 irq enabled", irq, 4'b0001);
    wr(4'd6, 32'b0001);
    rd(4'd7);                  chk("R8 cancel", lastRd, 0);
    ticks(10);
    rd(4'd8);                  chk("R8 no fire after cancel", lastRd, 32'b0001);
    wr(4'd8, 32'b1110);
    rd(4'd8);                  chk("R9 zeros no effect", lastRd, 32'b0001);
    wr(4'd8, 32'b0001);
    rd(4'd8);                  chk("R9 clear", lastRd, 0);
    @(negedge clk);            chk("R10 irq low after clear", irq, 4'b0000);

    // R6: disabled alarm ignores target write and never fires
    wr(4'd6, 32'd0);
    loSnap = mCnt[31:0];
    wr(4'd3, loSnap + 32'd2);
    ticks(5);
    rd(4'd8);                  chk("R6 disabled no fire", lastRd, 0);

    // R5/R7 random alarms
    for (int it = 0; it < 12; it++) begin
      int a;
      int k;
      a = $urandom % 4;
      k = 1 + $urandom % 20;
      wr(4'd6, 32'(bitOf(a)));
      loSnap = mCnt[31:0];
      wr(4'(2 + a), loSnap + 32'(k));
      ticks(k);
      rd(4'd7);                chk("R5 running pending", lastRd, 32'(bitOf(a)));
      rd(4'd8);                chk("R7 not yet", lastRd, 0);
      if (it % 3 == 0) begin
        // R9 fire and clear in the same cycle: set wins
        cyc(1'b1, 1'b1, 1'b1, 4'd8, 32'(bitOf(a)));
        rd(4'd8);              chk("R9 fire beats clear", lastRd, 32'(bitOf(a)));
      end else begin
        ticks(1);
        rd(4'd8);              chk("R7 fired", lastRd, 32'(bitOf(a)));
      end
      rd(4'd7);                chk("R7 running drop", lastRd, 0);
      @(negedge clk);          chk("R10 irq", irq, bitOf(a));
      wr(4'd8, 32'(bitOf(a)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule